// File: doc/BRIEF.md
# Bus Mastership Arbitration Client

This block sits on the requesting side of a shared external bus. The bus is owned by one of several masters, and an arbiter outside the block picks the next owner. Inside the device, the CPU and the DMA engine say when they need the external bus, and a software hold bit can ask for the bus on their behalf. The block turns these into an active-low bus request pin. It samples the arbiter's active-low grant and the shared active-low busy line on the clock. From these it decides when this device becomes master and may run external cycles, and when it must give the bus back.

Mastership starts only when grant is seen and the bus is no longer busy. While the device is master it pulls the busy line low. When grant is withdrawn, the device finishes the bus cycle in flight before it lets go. A locked read-modify-write input holds the bus across both halves of an indivisible access. The bus can also be parked: while grant stays asserted, the device keeps mastership even with its request withdrawn, so a later access pays no arbitration delay.

Top module: `bus_master_client`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `br_n` is 1, `is_master` is 0 and `busy_n_out` is 1.
- R2: `br_n` goes to 0 on the first rising edge at which `cpu_req` or `dma_req` is 1. It returns to 1 on the first edge at which both are 0 and `req_hold` is 0.
- R3: `req_hold` = 1 drives `br_n` to 0 one clock later, even when neither `cpu_req` nor `dma_req` is set.
- R4: `br_n` follows the rule of R2/R3 in the same way whether the device is master or slave.
- R5: `grant_n` and `busy_n_in` are registered on the clock. The device becomes master at the second rising edge after both pins show grant = 0 and busy = 1. It never becomes master otherwise.
- R6: While the registered busy is 0, the device stays slave even with grant asserted.
- R7: `busy_n_out` is 0 exactly in the cycles where `is_master` is 1.
- R8: If grant is lost while `cycle_active` is 1, the device stays master until a cycle with `cycle_end` = 1. It releases at that edge.
- R9: While the registered grant is 0, a master stays master whatever the requests are (parking).
- R10: While `lock_rmw` is 1, a master stays master even when grant has been removed.
- R11: When grant is removed with `cycle_active` = 0 and `lock_rmw` = 0, `is_master` falls at the second rising edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU needs the external bus |
| dma_req | input | 1 | DMA engine needs the external bus |
| req_hold | input | 1 | Software bit that forces the request on |
| lock_rmw | input | 1 | Indivisible read-modify-write in progress |
| cycle_active | input | 1 | An external bus cycle is in flight |
| cycle_end | input | 1 | The current bus cycle completes this clock |
| grant_n | input | 1 | Bus grant from the arbiter, active low |
| busy_n_in | input | 1 | Shared bus busy line, active low |
| br_n | output | 1 | Bus request to the arbiter, active low, always driven |
| busy_n_out | output | 1 | Busy drive from this device, active low |
| is_master | output | 1 | This device owns the bus and may start cycles |

## Verification
Each state problem shows up at the ports within two clocks of the stimulus that exposes it. If the tenure state is wrong, `is_master` and `busy_n_out` show it on the edge where a grant, busy or cycle-end event should have moved it. That edge is second after a pin change, or first after `cycle_end` or `lock_rmw`. A wrong request register shows on `br_n` one edge after the internal requests change. A reference model that tracks the two sampling registers and the ownership bit is compared with all three outputs on every clock. So a missed release, an early takeover or a lost park is reported in the cycle it happens.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [0:0] {
    TEN_SLAVE  = 1'b0,
    TEN_MASTER = 1'b1
  } tenure_t;
endpackage

// File: rtl/bmc_pin_sampler.sv
module bmc_pin_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_n,
  input  logic busy_n,
  output logic grant_on,
  output logic busy_on
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] g_pipe;
  logic [LAST:0] b_pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          g_pipe <= '0;
          b_pipe <= '0;
        end else begin
          g_pipe[0] <= ~grant_n;
          b_pipe[0] <= ~busy_n;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          g_pipe <= '0;
          b_pipe <= '0;
        end else begin
          g_pipe <= {g_pipe[LAST-1:0], ~grant_n};
          b_pipe <= {b_pipe[LAST-1:0], ~busy_n};
        end
      end
    end
  endgenerate

  assign grant_on = g_pipe[LAST];
  assign busy_on  = b_pipe[LAST];
endmodule

// File: rtl/bmc_req_gen.sv
module bmc_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic cpu_req,
  input  logic dma_req,
  input  logic req_hold,
  output logic br_n
);
  logic want;
  assign want = cpu_req | dma_req | req_hold;

  always_ff @(posedge clk) begin
    if (rst) br_n <= 1'b1;
    else     br_n <= ~want;
  end

  assert_req_on_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req || dma_req) |=> !br_n);
  assert_hold_on_R3: assert property (@(posedge clk) disable iff (rst)
    req_hold |=> !br_n);
  assert_req_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req && !dma_req && !req_hold) |=> br_n);
endmodule

// File: rtl/bmc_tenure_fsm.sv
module bmc_tenure_fsm
  import bmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic grant_on,
  input  logic busy_on,
  input  logic lock_rmw,
  input  logic cycle_active,
  input  logic cycle_end,
  output logic master
);
  tenure_t state_q, state_d;
  logic    cycle_done;

  assign cycle_done = ~cycle_active | cycle_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TEN_SLAVE:  if (grant_on && !busy_on) state_d = TEN_MASTER;
      TEN_MASTER: if (!grant_on && !lock_rmw && cycle_done) state_d = TEN_SLAVE;
      default:    state_d = TEN_SLAVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TEN_SLAVE;
    else     state_q <= state_d;
  end

  assign master = (state_q == TEN_MASTER);

  assert_take_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(master) |-> $past(grant_on && !busy_on));
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (!master && busy_on) |=> !master);
  assert_park_R9: assert property (@(posedge clk) disable iff (rst)
    (master && grant_on) |=> master);
  assert_lock_R10: assert property (@(posedge clk) disable iff (rst)
    (master && lock_rmw) |=> master);
  assert_cycle_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(master) |-> $past(!cycle_active || cycle_end));
endmodule

// File: rtl/bus_master_client.sv
module bus_master_client #(
  parameter int SAMPLE_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_req,
  input  logic dma_req,
  input  logic req_hold,
  input  logic lock_rmw,
  input  logic cycle_active,
  input  logic cycle_end,
  input  logic grant_n,
  input  logic busy_n_in,
  output logic br_n,
  output logic busy_n_out,
  output logic is_master
);
  logic grant_on;
  logic busy_on;
  logic master;

  bmc_pin_sampler #(.STAGES(SAMPLE_STAGES)) u_sample (
    .clk(clk), .rst(rst),
    .grant_n(grant_n), .busy_n(busy_n_in),
    .grant_on(grant_on), .busy_on(busy_on)
  );

  bmc_req_gen u_req (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .dma_req(dma_req), .req_hold(req_hold),
    .br_n(br_n)
  );

  bmc_tenure_fsm u_fsm (
    .clk(clk), .rst(rst),
    .grant_on(grant_on), .busy_on(busy_on),
    .lock_rmw(lock_rmw), .cycle_active(cycle_active), .cycle_end(cycle_end),
    .master(master)
  );

  assign is_master  = master;
  assign busy_n_out = ~master;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (br_n && !is_master));
endmodule

// File: tb/tb_bus_master_client.sv
module tb_bus_master_client;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 0, dma_req = 0, req_hold = 0, lock_rmw = 0;
  logic cycle_active = 0, cycle_end = 0;
  logic grant_n = 1, busy_n_in = 1;
  logic br_n, busy_n_out, is_master;

  always #5 clk = ~clk;

  bus_master_client dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
    .req_hold(req_hold), .lock_rmw(lock_rmw), .cycle_active(cycle_active),
    .cycle_end(cycle_end), .grant_n(grant_n), .busy_n_in(busy_n_in),
    .br_n(br_n), .busy_n_out(busy_n_out), .is_master(is_master)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // Behavioural reference: sampled pins, owner bit, request bit
  int m_br = 1, m_gs = 0, m_bs = 0, m_own = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_br = 1; m_gs = 0; m_bs = 0; m_own = 0;
    end else begin
      if (m_own == 0) begin
        if (m_gs == 1 && m_bs == 0) m_own = 1;
      end else begin
        if (m_gs == 0 && !lock_rmw && (!cycle_active || cycle_end)) m_own = 0;
      end
      m_gs = grant_n ? 0 : 1;
      m_bs = busy_n_in ? 0 : 1;
      m_br = (cpu_req || dma_req || req_hold) ? 0 : 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, "br_n", int'(br_n), m_br);
      chk(tag, "is_master", int'(is_master), m_own);
      chk("R7", "busy_n_out", int'(busy_n_out), is_master ? 0 : 1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    step(2);
    chk("R1", "br_n in reset", int'(br_n), 1);
    rst = 0;
    step(1);
    chk("R1", "is_master after reset", int'(is_master), 0);
    chk("R1", "busy_n_out after reset", int'(busy_n_out), 1);

    tag = "R2";
    cpu_req = 1; step(1);
    chk("R2", "br_n after cpu_req", int'(br_n), 0);
    cpu_req = 0; step(1);
    chk("R2", "br_n after drop", int'(br_n), 1);
    dma_req = 1; step(2);
    chk("R2", "br_n with dma_req", int'(br_n), 0);
    dma_req = 0; step(1);

    tag = "R3";
    req_hold = 1; step(1);
    chk("R3", "br_n with hold only", int'(br_n), 0);
    req_hold = 0; step(1);
    chk("R3", "br_n hold released", int'(br_n), 1);

    tag = "R6";
    cpu_req = 1; grant_n = 0; busy_n_in = 0;
    step(4);
    chk("R6", "slave while busy", int'(is_master), 0);

    tag = "R5";
    busy_n_in = 1; step(1);
    chk("R5", "not yet master after 1 edge", int'(is_master), 0);
    step(1);
    chk("R5", "master after 2 edges", int'(is_master), 1);
    chk("R7", "busy driven while master", int'(busy_n_out), 0);

    tag = "R9";
    cpu_req = 0; step(4);
    chk("R9", "parked master", int'(is_master), 1);
    chk("R9", "request withdrawn while parked", int'(br_n), 1);

    tag = "R4";
    dma_req = 1; step(1);
    chk("R4", "request while master", int'(br_n), 0);
    dma_req = 0;

    tag = "R8";
    cycle_active = 1; grant_n = 1; step(5);
    chk("R8", "held through active cycle", int'(is_master), 1);
    cycle_end = 1; step(1);
    chk("R8", "released at cycle end", int'(is_master), 0);
    cycle_end = 0; cycle_active = 0;

    tag = "R4";
    cpu_req = 1; step(1);
    chk("R4", "request while slave", int'(br_n), 0);
    cpu_req = 0;

    tag = "R10";
    grant_n = 0; step(2);
    chk("R10", "regained", int'(is_master), 1);
    lock_rmw = 1; grant_n = 1; step(4);
    chk("R10", "locked keeps bus", int'(is_master), 1);
    lock_rmw = 0; step(1);
    chk("R10", "release after unlock", int'(is_master), 0);

    tag = "R11";
    grant_n = 0; step(3);
    chk("R11", "master again", int'(is_master), 1);
    grant_n = 1; step(1);
    chk("R11", "still master one edge after loss", int'(is_master), 1);
    step(1);
    chk("R11", "released second edge", int'(is_master), 0);

    tag = "R1";
    grant_n = 0; req_hold = 1; step(3);
    rst = 1; step(1);
    chk("R1", "br_n mid-run reset", int'(br_n), 1);
    chk("R1", "is_master mid-run reset", int'(is_master), 0);
    rst = 0; req_hold = 0; grant_n = 1;
    step(3);

    finish_run();
  end
endmodule